// File: doc/BRIEF.md
# System Reset Control Port

This block is a one-byte control register placed on a simple I/O bus at port address 0x0CF9. Software writes the byte to ask for a full system reset and can read back the reset type it selected earlier. The block compares the bus address against its port number, keeps a single reset-type flag and answers reads with that flag. When a write sets the trigger bit, it sends a one-clock request to the system reset logic.

The trigger bit is never stored. A write that carries it fires the request and leaves the stored flag as it was. A write without it replaces the stored byte with the reset-type bit alone, and every other bit reads back as zero. Reads are combinational: the byte appears on the read bus in the same cycle as the read strobe. When the port is not being read, the read bus is driven to zero, so it can be ORed with other bus sources.

Top module: `rcp_port`

## Requirements
- R1: Only an access whose address equals the port parameter (default 0x0CF9) is decoded.
- R2: A write to the port with data bit 2 set drives `sys_reset_req` high in the clock cycle that follows the write edge.
- R3: A write to the port with data bit 2 clear stores data bit 1 as the reset-type flag and stores every other bit as zero.
- R4: A read of the port returns the stored byte on `io_rdata` in the same cycle as the read strobe.
- R5: A write with data bit 2 set leaves the stored byte unchanged.
- R6: While reset is active, and after it is released, the stored byte is zero and `sys_reset_req` is low.
- R7: A write to any other address changes neither the stored byte nor `sys_reset_req`.
- R8: `io_rdata` is zero whenever the port is not being read.
- R9: `sys_reset_req` lasts one clock for each triggering write and falls in the cycle after the last triggering write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte; zero when the port is not being read |
| sys_reset_req | output | 1 | One-clock system reset request |

## Verification
The read result has no latency: the bench drives the address and read strobe after a falling edge and samples `io_rdata` 1 ns later, before the next rising edge. A write takes effect at the rising edge where the strobe is high. The bench checks the reset request at the next falling edge, which is half a clock after that edge, and checks that it has dropped one falling edge later. It checks the stored byte by reading it back after the write strobe has been removed. After reset is released, the bench waits three cycles, which covers the two-stage release synchronizer, and only then starts its first access.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  // Kind of access the address decoder hands to the storage and pulse logic.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FIRE  = 2'd2
  } acc_e;

endpackage

// File: rtl/rcp_rst_sync.sv
module rcp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/rcp_decode.sv
module rcp_decode
  import rcp_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              fire_bit,
  output acc_e              acc,
  output logic              rd_hit
);

  logic sel;

  always_comb begin
    sel    = (io_addr == PORT_ADDR);
    rd_hit = sel && io_rd;
    acc    = ACC_IDLE;
    if (sel && io_wr) begin
      // The trigger bit takes priority: such a write never stores.
      if (fire_bit) acc = ACC_FIRE;
      else          acc = ACC_STORE;
    end
  end

endmodule

// File: rtl/rcp_store.sv
module rcp_store
  import rcp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  acc_e              acc,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata
);

  localparam logic [DATA_W-1:0] TYPE_MASK = DATA_W'(1) << TYPE_BIT;

  logic [DATA_W-1:0] kept_q;
  logic [DATA_W-1:0] kept_d;
  logic              kept_en;

  always_comb begin
    kept_en = (acc == ACC_STORE);
    kept_d  = io_wdata & TYPE_MASK;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     kept_q <= '0;
    else if (kept_en) kept_q <= kept_d;
  end

  always_comb begin
    io_rdata = rd_hit ? kept_q : '0;
  end

  // R3: a storing write leaves exactly the reset-type bit of its data
  assert_store_type_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc == ACC_STORE) |=> (kept_q[TYPE_BIT] == $past(io_wdata[TYPE_BIT])));

  // R5: a triggering write keeps the stored byte
  assert_fire_keeps_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc == ACC_FIRE) |=> $stable(kept_q));

  // R7: idle cycles (including other addresses) keep the stored byte
  assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc == ACC_IDLE) |=> $stable(kept_q));

endmodule

// File: rtl/rcp_pulse.sv
module rcp_pulse
  import rcp_pkg::*;
(
  input  logic clk,
  input  logic rst_q_n,
  input  acc_e acc,
  output logic sys_reset_req
);

  logic req_q;
  logic req_d;

  always_comb begin
    req_d = (acc == ACC_FIRE);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) req_q <= 1'b0;
    else          req_q <= req_d;
  end

  assign sys_reset_req = req_q;

  // R2: a triggering write raises the request on the next cycle
  assert_fire_raises_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc == ACC_FIRE) |=> sys_reset_req);

  // R9: the request is only high right after a triggering write
  assert_req_source_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    sys_reset_req |-> $past(acc == ACC_FIRE));

endmodule

// File: rtl/rcp_port.sv
module rcp_port
  import rcp_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter int               DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9,
  parameter int               TYPE_BIT  = 1,
  parameter int               FIRE_BIT  = 2,
  parameter int               SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              sys_reset_req
);

  logic rst_q_n;
  acc_e acc;
  logic rd_hit;

  rcp_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  rcp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .fire_bit (io_wdata[FIRE_BIT]),
    .acc      (acc),
    .rd_hit   (rd_hit)
  );

  rcp_store #(.DATA_W(DATA_W), .TYPE_BIT(TYPE_BIT)) u_store (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .acc      (acc),
    .rd_hit   (rd_hit),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata)
  );

  rcp_pulse u_pulse (
    .clk           (clk),
    .rst_q_n       (rst_q_n),
    .acc           (acc),
    .sys_reset_req (sys_reset_req)
  );

  // R8: no read of the port means a quiet read bus
  assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!io_rd || (io_addr != PORT_ADDR)) |-> (io_rdata == '0));

  // R7: a write elsewhere never raises the request
  assert_other_addr_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (io_wr && (io_addr != PORT_ADDR)) |=> !sys_reset_req);

endmodule

// File: tb/sim_rcp_port.sv
module sim_rcp_port;

  localparam logic [15:0] PORT = 16'h0CF9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        sys_reset_req;

  int   n_vec  = 0;
  int   n_fail = 0;
  logic [7:0] exp_kept;

  always #10 clk = ~clk;

  rcp_port u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_addr       (io_addr),
    .io_wr         (io_wr),
    .io_rd         (io_rd),
    .io_wdata      (io_wdata),
    .io_rdata      (io_rdata),
    .sys_reset_req (sys_reset_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write then check the request at the next two falling edges.
  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
    bit fire;
    fire = (a == PORT) && d[2];
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    #1;
    check(sys_reset_req == fire, req, sys_reset_req, fire);
    @(negedge clk);
    #1;
    check(sys_reset_req == 1'b0, "R9", sys_reset_req, 0);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    check(io_rdata == exp, req, io_rdata, exp);
    io_rd = 1'b0;
    #1;
    check(io_rdata == 8'h00, "R8", io_rdata, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    exp_kept = 8'h00;
    repeat (3) @(negedge clk);
    io_addr = PORT; io_rd = 1'b1;
    #1;
    check(io_rdata == 8'h00, "R6", io_rdata, 0);
    check(sys_reset_req == 1'b0, "R6", sys_reset_req, 0);
    io_rd = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(PORT, 8'h00, "R6");

    // R2 R3 R4 R5: every data byte written to the port
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'(v);
      if (d[2]) begin
        do_write(PORT, d, "R2");
        do_read(PORT, exp_kept, "R5");
      end else begin
        do_write(PORT, d, "R2");
        exp_kept = d & 8'h02;
        do_read(PORT, exp_kept, "R3");
      end
    end

    // R1 R7: neighbour addresses and single-bit address flips
    do_write(PORT, 8'h02, "R3");
    exp_kept = 8'h02;
    for (int b = 0; b < 16; b++) begin
      logic [15:0] a;
      a = PORT ^ (16'h1 << b);
      do_write(a, 8'h04, "R7");
      do_write(a, 8'h00, "R7");
      do_read(PORT, exp_kept, "R7");
      do_read(a, 8'h00, "R1");
    end
    do_write(16'h0CF8, 8'hFF, "R7");
    do_write(16'h0CFA, 8'h00, "R7");
    do_read(PORT, exp_kept, "R4");

    // R9: two triggering writes back to back give two cycles of request
    @(negedge clk);
    io_addr = PORT; io_wdata = 8'h04; io_wr = 1'b1;
    @(negedge clk);
    io_wdata = 8'h06;
    #1;
    check(sys_reset_req == 1'b1, "R9", sys_reset_req, 1);
    @(negedge clk);
    io_wr = 1'b0;
    #1;
    check(sys_reset_req == 1'b1, "R9", sys_reset_req, 1);
    @(negedge clk);
    #1;
    check(sys_reset_req == 1'b0, "R9", sys_reset_req, 0);
    do_read(PORT, exp_kept, "R5");

    // R6: reset in mid-run clears the stored flag
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    io_addr = PORT; io_rd = 1'b1;
    #1;
    check(io_rdata == 8'h00, "R6", io_rdata, 0);
    io_rd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_kept = 8'h00;
    do_read(PORT, 8'h00, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule